// File: doc/BRIEF.md
# I2S to Simultaneous Stereo Burst Bridge

The bridge receives a standard I2S stream carrying 16-bit two's-complement stereo samples in 64-bit frames. It re-serialises each sample pair for a stereo DAC that loads both channels at once. For every frame it emits one latch strobe, then one burst of 16 output clock pulses. During that burst the left and right words appear bit by bit on two separate data lines. Both words are in offset binary form. The conversion inverts only the leading bit of each word as that bit passes through.

A 5-bit slot counter is advanced by the recovered bit clock and re-aligned at every word-select edge. It locates the sample bits, the leading bit and the burst window. The left word is collected during its own slot and replayed during the right slot, so it is held back by one full channel period. The right word streams straight through. Outside the burst every output sits at zero, which leaves roughly three quarters of each frame free of switching.

All logic runs on one system clock that must be at least eight times the bit clock rate. The three input lines are synchronised before any edge is detected. After reset, or after a word-select edge at the wrong slot count, the outputs stay idle until the frame timing has been confirmed again.

Top module: `i2s_burst_bridge`

## Requirements
- R1: Input bits are taken on rising edges of `in_sclk`. The first data bit (MSB) of a slot is sampled on the second rising edge after `in_lrck` changes. `in_lrck` low selects the left slot and high selects the right slot. Each slot is 32 bit periods long, and its first 16 bits form the sample, MSB first.
- R2: Each output word equals its input word with bit 15 inverted and bits 14..0 unchanged (two's complement to offset binary).
- R3: The left and right words of the same frame are shifted out in the same burst. Bit k of both words is presented for the same output clock pulse, MSB first.
- R4: Each burst holds exactly 16 rising edges of `dac_sclk`.
- R5: `dac_latch` is high for exactly one input bit period. It falls when the MSB is presented, half a bit period before the first `dac_sclk` rising edge, and `dac_sclk` stays low while it is high.
- R6: `dac_sdl` and `dac_sdr` change only while `dac_sclk` is low, so they are stable at every `dac_sclk` rising edge.
- R7: Outside the latch-and-burst window all four outputs are held at 0, and all output activity in a frame lies within 17 input bit periods.
- R8: After reset, bursts are produced only once two correctly spaced `in_lrck` edges (32 bit periods apart) have been seen. The first burst comes at the next correctly spaced entry into the right slot. With a stream that starts aligned to reset, the first frame is silent and the second frame bursts.
- R9: An `in_lrck` edge at any slot count other than 32, or a slot that runs past 32 periods without an edge, stops any burst at once and drops the lock. The frame that contains the fault and the next full frame stay silent, and bursting resumes in the frame after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the input bit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sclk | input | 1 | Input serial bit clock |
| in_lrck | input | 1 | Input word select, low = left |
| in_sdata | input | 1 | Input serial data, two's complement, MSB first |
| dac_sclk | output | 1 | Gated output bit clock, 16 pulses per frame |
| dac_latch | output | 1 | Latch strobe, one bit period, ahead of the MSB |
| dac_sdl | output | 1 | Left channel output data, offset binary |
| dac_sdr | output | 1 | Right channel output data, offset binary |

## Verification
A slot counter that is off by one shows up in the very first burst. The replayed words come out shifted, and the leading-bit inversion lands on the wrong bit, so both decoded words miss their expected values within a single frame. A fault in the lock state shows as a burst in a frame that must stay silent, or as a missing burst in a frame that must carry one, within one or two frames of reset or of a misplaced word-select edge. Faults in the output stage show as a pulse count other than 16, a latch width other than one bit period, or data moving while the output clock is high, and all of these are visible in the same frame.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

    localparam int SBB_WORD_W     = 16;
    localparam int SBB_SLOT_W     = 32;
    localparam int SBB_LOCK_EDGES = 2;
    localparam int SBB_SYNC_STAGES = 2;

    // Events seen on the synchronised input lines, one system cycle wide.
    typedef struct packed {
        logic rise;
        logic fall;
        logic ws;
        logic sd;
    } line_ev_t;

    // Decoded slot information, valid in the cycle of an input edge.
    typedef struct packed {
        logic rise;   // input bit clock rising edge
        logic fall;   // input bit clock falling edge
        logic start;  // locked, correctly spaced entry into the right slot
        logic bad;    // framing fault seen on this edge
        logic word;   // current bit lies inside the 16-bit sample
        logic msb;    // current bit is the leading bit
        logic chan;   // 0 = left slot, 1 = right slot
        logic dbit;   // data bit after sign-to-offset conversion
    } slot_ev_t;

    function automatic logic to_offset(input logic b, input logic lead);
        return b ^ lead;
    endfunction

endpackage

// File: rtl/sbb_edge_sync.sv
module sbb_edge_sync
    import sbb_pkg::*;
#(
    parameter int STAGES = SBB_SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_i,
    input  logic     lrck_i,
    input  logic     sdata_i,
    output line_ev_t ev
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              sclk_d;

    assign raw = {sclk_i, lrck_i, sdata_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= synced[2];
    end

    always_comb begin
        ev.rise = synced[2] & ~sclk_d;
        ev.fall = ~synced[2] & sclk_d;
        ev.ws   = synced[1];
        ev.sd   = synced[0];
    end

endmodule

// File: rtl/sbb_slot_track.sv
module sbb_slot_track
    import sbb_pkg::*;
#(
    parameter int WORD_W     = SBB_WORD_W,
    parameter int SLOT_W     = SBB_SLOT_W,
    parameter int LOCK_EDGES = SBB_LOCK_EDGES
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    output slot_ev_t se
);
    localparam int CNT_W = $clog2(SLOT_W);
    localparam int ST_W  = $clog2(LOCK_EDGES + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

    logic [CNT_W-1:0] cnt;
    logic [ST_W-1:0]  stage;
    logic             ws_last;

    logic ws_edge, good_edge, fault;

    always_comb begin
        ws_edge   = ev.rise && (ev.ws != ws_last);
        good_edge = ws_edge && (cnt == LAST);
        fault     = ev.rise && ((ws_edge && cnt != LAST) || (!ws_edge && cnt == LAST));

        se.rise  = ev.rise;
        se.fall  = ev.fall;
        se.bad   = fault;
        se.chan  = ev.ws;
        se.start = good_edge && ev.ws && (int'(stage) >= LOCK_EDGES);
        se.word  = ev.rise && !ws_edge && (int'(cnt) < WORD_W);
        se.msb   = ev.rise && !ws_edge && (cnt == '0);
        se.dbit  = to_offset(ev.sd, se.msb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            stage   <= '0;
            ws_last <= 1'b0;
        end else if (ev.rise) begin
            ws_last <= ev.ws;
            cnt     <= ws_edge ? '0 : cnt + 1'b1;
            if (fault)
                stage <= '0;
            else if (good_edge && int'(stage) < LOCK_EDGES)
                stage <= stage + 1'b1;
        end
    end

    // A fault always clears the lock before the next bit edge.
    AST_FAULT_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        se.bad |=> (stage == '0)) else $error("lock kept after fault"); // R9

endmodule

// File: rtl/sbb_burst_out.sv
module sbb_burst_out
    import sbb_pkg::*;
#(
    parameter int WORD_W = SBB_WORD_W
) (
    input  logic     clk,
    input  logic     rst,
    input  slot_ev_t se,
    output logic     sclk_o,
    output logic     latch_o,
    output logic     sdl_o,
    output logic     sdr_o
);
    localparam int PC_W = $clog2(WORD_W + 2);

    logic [WORD_W-1:0] cap_sh;
    logic [WORD_W-1:0] play;
    logic              run;
    logic              pulse_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_sh   <= '0;
            play     <= '0;
            run      <= 1'b0;
            pulse_ok <= 1'b0;
            sclk_o   <= 1'b0;
            latch_o  <= 1'b0;
            sdl_o    <= 1'b0;
            sdr_o    <= 1'b0;
        end else if (se.bad) begin
            run      <= 1'b0;
            pulse_ok <= 1'b0;
            sclk_o   <= 1'b0;
            latch_o  <= 1'b0;
            sdl_o    <= 1'b0;
            sdr_o    <= 1'b0;
        end else if (se.rise) begin
            sclk_o <= 1'b0;
            if (se.word && !se.chan)
                cap_sh <= {cap_sh[WORD_W-2:0], se.dbit};
            if (se.start) begin
                latch_o <= 1'b1;
                play    <= cap_sh;
                run     <= 1'b1;
            end else if (run && se.word && se.chan) begin
                latch_o  <= 1'b0;
                sdl_o    <= play[WORD_W-1];
                play     <= {play[WORD_W-2:0], 1'b0};
                sdr_o    <= se.dbit;
                pulse_ok <= 1'b1;
            end else if (run) begin
                run      <= 1'b0;
                latch_o  <= 1'b0;
                pulse_ok <= 1'b0;
                sdl_o    <= 1'b0;
                sdr_o    <= 1'b0;
            end
        end else if (se.fall) begin
            sclk_o <= pulse_ok;
        end
    end

    // Checker state: output clock pulses since the last latch strobe.
    logic [PC_W-1:0] pulse_cnt;
    logic            sclk_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_cnt <= '0;
            sclk_q    <= 1'b0;
        end else begin
            sclk_q <= sclk_o;
            if (latch_o)
                pulse_cnt <= '0;
            else if (sclk_o && !sclk_q && int'(pulse_cnt) <= WORD_W)
                pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        int'(pulse_cnt) <= WORD_W) else $error("too many pulses"); // R4
    AST_LATCH_NO_CLK: assert property (@(posedge clk) disable iff (rst)
        latch_o |-> !sclk_o) else $error("clock during latch"); // R5
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> ($stable(sdl_o) && $stable(sdr_o))) else $error("data moved"); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!sclk_o && !latch_o && !sdl_o && !sdr_o)) else $error("noise"); // R7
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        se.start |-> !run) else $error("overlapping burst"); // R3

endmodule

// File: rtl/i2s_burst_bridge.sv
module i2s_burst_bridge
    import sbb_pkg::*;
#(
    parameter int WORD_W      = SBB_WORD_W,
    parameter int SLOT_W      = SBB_SLOT_W,
    parameter int LOCK_EDGES  = SBB_LOCK_EDGES,
    parameter int SYNC_STAGES = SBB_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic in_sclk,
    input  logic in_lrck,
    input  logic in_sdata,
    output logic dac_sclk,
    output logic dac_latch,
    output logic dac_sdl,
    output logic dac_sdr
);
    line_ev_t lev;
    slot_ev_t sev;

    sbb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_i(in_sclk), .lrck_i(in_lrck), .sdata_i(in_sdata),
        .ev(lev)
    );

    sbb_slot_track #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .LOCK_EDGES(LOCK_EDGES)) u_track (
        .clk(clk), .rst(rst), .ev(lev), .se(sev)
    );

    sbb_burst_out #(.WORD_W(WORD_W)) u_out (
        .clk(clk), .rst(rst), .se(sev),
        .sclk_o(dac_sclk), .latch_o(dac_latch),
        .sdl_o(dac_sdl), .sdr_o(dac_sdr)
    );

endmodule

// File: tb/sim_i2s_burst_bridge.sv
module sim_i2s_burst_bridge;
    localparam int HALF = 5;
    localparam int PER  = 2 * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_sclk = 1'b0, in_lrck = 1'b0, in_sdata = 1'b0;
    logic dac_sclk, dac_latch, dac_sdl, dac_sdr;

    always #5 clk = ~clk;

    i2s_burst_bridge u0 (
        .clk(clk), .rst(rst), .in_sclk(in_sclk), .in_lrck(in_lrck),
        .in_sdata(in_sdata), .dac_sclk(dac_sclk), .dac_latch(dac_latch),
        .dac_sdl(dac_sdl), .dac_sdr(dac_sdr)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int frame_id = 0;

    // Output monitor, restarted whenever frame_id changes.
    int seen_id = 0;
    int m_cyc, m_first, m_last, m_pulse, m_le_rise, m_le_run, m_le_len;
    int m_gap, m_gap_run, m_r6;
    bit m_gap_on;
    logic [15:0] m_lw, m_rw;
    logic p_sclk = 0, p_latch = 0, p_dl = 0, p_dr = 0;

    always @(negedge clk) begin
        if (frame_id != seen_id) begin
            seen_id = frame_id;
            m_cyc = 0; m_first = -1; m_last = -1; m_pulse = 0; m_le_rise = 0;
            m_le_run = 0; m_le_len = 0; m_gap = -1; m_gap_run = 0; m_r6 = 0;
            m_gap_on = 0; m_lw = '0; m_rw = '0;
        end else m_cyc++;
        if (dac_sclk != p_sclk || dac_latch != p_latch || dac_sdl != p_dl || dac_sdr != p_dr) begin
            if (m_first < 0) m_first = m_cyc;
            m_last = m_cyc;
        end
        if (dac_latch && !p_latch) m_le_rise++;
        if (dac_latch) m_le_run++;
        if (!dac_latch && p_latch) begin
            m_le_len = m_le_run; m_le_run = 0; m_gap_on = 1; m_gap_run = 0;
        end else if (m_gap_on) begin
            m_gap_run++;
            if (dac_sclk && !p_sclk) begin m_gap = m_gap_run; m_gap_on = 0; end
        end
        if (dac_sclk && !p_sclk) begin
            m_pulse++;
            m_lw = {m_lw[14:0], dac_sdl};
            m_rw = {m_rw[14:0], dac_sdr};
        end
        if (dac_sclk && (dac_sdl != p_dl || dac_sdr != p_dr)) m_r6++;
        p_sclk = dac_sclk; p_latch = dac_latch; p_dl = dac_sdl; p_dr = dac_sdr;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One I2S frame; left slot may be shortened to provoke a framing fault.
    task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int left_len);
        frame_id++;
        for (int k = 0; k < left_len + 32; k++) begin
            in_lrck  = (k >= left_len - 1 && k < left_len + 31);
            if (k < 16)                          in_sdata = l[15-k];
            else if (k >= left_len && k < left_len + 16) in_sdata = r[15-(k-left_len)];
            else                                 in_sdata = 1'b0;
            repeat (HALF) @(negedge clk);
            in_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            in_sclk = 1'b0;
        end
    endtask

    task automatic test_burst(input logic [15:0] l, input logic [15:0] r);
        send_frame(l, r, 32);
        chk(m_pulse == 16, "R4", "pulse count", m_pulse, 16);
        chk(m_lw == (l ^ 16'h8000), "R2", "left word", m_lw, l ^ 16'h8000);
        chk(m_rw == (r ^ 16'h8000), "R3", "right word", m_rw, r ^ 16'h8000);
        chk(m_le_rise == 1, "R5", "latch strobes", m_le_rise, 1);
        chk(m_le_len == PER, "R5", "latch width", m_le_len, PER);
        chk(m_gap == HALF, "R5", "latch to first clock", m_gap, HALF);
        chk(m_r6 == 0, "R6", "data moves with clock high", m_r6, 0);
        chk(m_last - m_first <= 17 * PER, "R7", "activity span", m_last - m_first, 17 * PER);
    endtask

    task automatic test_silent(input logic [15:0] l, input logic [15:0] r, input int left_len, input string req);
        send_frame(l, r, left_len);
        chk(m_pulse == 0, req, "pulses in silent frame", m_pulse, 0);
        chk(m_le_rise == 0, req, "latch in silent frame", m_le_rise, 0);
        chk(m_first < 0, req, "any output activity", m_first, -1);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R7 reset state: all outputs low
        chk({dac_sclk, dac_latch, dac_sdl, dac_sdr} == 4'b0, "R7", "reset outputs",
            {dac_sclk, dac_latch, dac_sdl, dac_sdr}, 0);
        test_silent(16'h1111, 16'h2222, 32, "R8");   // first frame after reset
        test_burst(16'h1234, 16'hA5C3);              // R1 R2 R3
        test_burst(16'h8000, 16'h7FFF);              // extremes
        test_burst(16'h0000, 16'hFFFF);
        test_burst(16'hFFFF, 16'h0001);
        test_silent(16'h4321, 16'h5678, 20, "R9");   // misplaced word-select edge
        test_silent(16'h0F0F, 16'hF0F0, 32, "R9");   // relocking frame
        test_burst(16'h7E81, 16'h8001);              // R9 bursting resumes
        test_burst(16'hC3A5, 16'h5A3C);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule